// File: doc/BRIEF.md
# Crosspoint Routing Configuration Store

This block holds the routing map of a 68-output crosspoint switch. It also holds the map for one extra monitor output, which sits at slot index 68. For every slot it drives an input code and a one-hot select vector to the multiplexer array. Each slot has two registers. A programming write lands in the slot's pending (shadow) register. The live (main) register copies the pending register on every clock cycle while the commit level is high, and keeps its value while commit is low. Holding commit high therefore makes each write take effect one cycle after it is stored.

The block has two ways of writing. In parallel mode, a rising edge on the load strobe writes the input code into one slot. The slot address comes either from a separate address field or, in multiplexed-bus use, from a value taken off the input-code bus when the address-latch strobe falls. In broadcast mode, one load edge carries a page number and a bitmap of that page's outputs. Every marked output receives the same input code. An init level restores the straight-through map, in which output i takes input i. Any code that does not name a real input switches the output off: its select vector is all zero and its power-down flag is raised. All strobes are edge-detected in one clock domain.

Top module: `xbar_cfg_mem`

## Requirements
- R1: After reset, slot i holds code i for every i below NUM_IN. Any slot without a matching input, including the monitor slot NUM_OUT, holds the all-ones disable code. For the bench parameters only bit 10 of powerDown is set.
- R2: With burstMode=0, muxAddrMode=0 and commitIn=1, a rising edge of loadIn writes inSel into the slot addressed by outField[ID_W-1:0]. The new code appears on selCode slot field [i*ID_W +: ID_W] after the second rising clock edge. Keeping loadIn high writes nothing further.
- R3: While commitIn is low, selCode does not change. Codes stored during that time appear one clock after commitIn goes high.
- R4: With muxAddrMode=1, the falling edge of aleIn captures inSel as the slot address. The next load rising edge writes the inSel value present at that moment into the captured slot, and outField is ignored.
- R5: With burstMode=1, one load rising edge writes inSel into every slot page*PAGE_OUT+b for which bit b of outField[PAGE_OUT-1:0] is 1. The page is taken from outField[PAGE_OUT +: 2]. All other slots keep their codes.
- R6: In broadcast mode, bitmap bits that map past the last data output are ignored. The monitor slot cannot be written this way.
- R7: In parallel mode, an address above NUM_OUT changes no slot. Address NUM_OUT writes the monitor slot.
- R8: While initIn is high, the shadow and main registers of all slots take the straight-through map of R1, whatever the level of commitIn.
- R9: A slot holding a code of NUM_IN or above shows an all-zero select vector and sets its powerDown bit. Writing a code below NUM_IN enables the slot again.
- R10: A slot holding code c below NUM_IN shows exactly one select bit, at bit c of selOneHot field [i*NUM_IN +: NUM_IN].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset (straight-through map) |
| burstMode | input | 1 | 1 = broadcast write, 0 = parallel write |
| muxAddrMode | input | 1 | 1 = slot address comes from the latched bus value |
| loadIn | input | 1 | Write strobe; acts on its rising edge |
| aleIn | input | 1 | Address-latch strobe; acts on its falling edge |
| commitIn | input | 1 | Main registers follow shadow registers while high |
| initIn | input | 1 | Loads the straight-through map while high |
| inSel | input | ID_W | Input code, or slot address in multiplexed use |
| outField | input | 2+PAGE_OUT | Slot address (low ID_W bits) or page and bitmap |
| selCode | output | NUM_SLOT*ID_W | Live input code per slot |
| selOneHot | output | NUM_SLOT*NUM_IN | One-hot select vector per slot |
| powerDown | output | NUM_SLOT | Slot disabled flag |

## Verification
The bench builds the block with NUM_OUT=10, NUM_IN=10 and ID_W=4. With these values PAGE_OUT is 3, so page 3 holds only output 9 and two of its bitmap bits point past the last output. Parallel address 12 fits the address field but has no slot. Codes 10 to 14 exercise the range between the last valid input and the all-ones disable code 15. All of these edges are within a few directed writes of each other, which keeps the bench short.

// File: rtl/xbar_cfg_pkg.sv
package xbar_cfg_pkg;
  typedef struct packed {
    logic init;    // load straight-through map
    logic commit;  // main follows shadow
    logic write;   // one write this cycle
    logic burst;   // write uses page bitmap
  } cfg_strobe_t;
endpackage

// File: rtl/xbar_cfg_ctrl.sv
module xbar_cfg_ctrl #(
  parameter int ID_W = 7
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         burstMode,
  input  logic                         muxAddrMode,
  input  logic                         loadIn,
  input  logic                         aleIn,
  input  logic                         commitIn,
  input  logic                         initIn,
  input  logic [ID_W-1:0]              inSel,
  input  logic [ID_W-1:0]              fieldAddr,
  output xbar_cfg_pkg::cfg_strobe_t    stb,
  output logic [ID_W-1:0]              wrAddr
);
  logic prevLoad, prevAle;
  logic [ID_W-1:0] addrLatch;
  logic aleFall;

  assign aleFall = prevAle & ~aleIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevLoad  <= 1'b0;
      prevAle   <= 1'b0;
      addrLatch <= '0;
    end else begin
      prevLoad <= loadIn;
      prevAle  <= aleIn;
      if (aleFall) addrLatch <= inSel;
    end
  end

  always_comb begin
    stb.init   = initIn;
    stb.commit = commitIn;
    stb.write  = loadIn & ~prevLoad;
    stb.burst  = burstMode;
    wrAddr     = muxAddrMode ? addrLatch : fieldAddr;
  end
endmodule

// File: rtl/xbar_cfg_datapath.sv
module xbar_cfg_datapath #(
  parameter int NUM_OUT  = 68,
  parameter int NUM_IN   = 68,
  parameter int ID_W     = 7,
  parameter int PAGE_OUT = 17,
  parameter int PAGE_W   = 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  xbar_cfg_pkg::cfg_strobe_t      stb,
  input  logic [ID_W-1:0]                wrAddr,
  input  logic [ID_W-1:0]                wrCode,
  input  logic [PAGE_W-1:0]              page,
  input  logic [PAGE_OUT-1:0]            pageMap,
  output logic [(NUM_OUT+1)*ID_W-1:0]    mainCodes
);
  localparam int NUM_SLOT = NUM_OUT + 1;

  for (genvar g = 0; g < NUM_SLOT; g++) begin : g_slot
    localparam logic [ID_W-1:0] INIT_CODE = (g < NUM_IN) ? ID_W'(g) : '1;
    logic [ID_W-1:0] shadowQ, mainQ;
    logic addrHit, burstHit;

    assign addrHit = (int'(wrAddr) == g);

    if (g < NUM_OUT) begin : g_pg
      localparam int PG = g / PAGE_OUT;
      localparam int BT = g % PAGE_OUT;
      assign burstHit = (int'(page) == PG) && pageMap[BT];
    end else begin : g_mon
      assign burstHit = 1'b0;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shadowQ <= INIT_CODE;
        mainQ   <= INIT_CODE;
      end else if (stb.init) begin
        shadowQ <= INIT_CODE;
        mainQ   <= INIT_CODE;
      end else begin
        if (stb.write && (stb.burst ? burstHit : addrHit)) shadowQ <= wrCode;
        if (stb.commit) mainQ <= shadowQ;
      end
    end

    assign mainCodes[g*ID_W +: ID_W] = mainQ;
  end
endmodule

// File: rtl/xbar_sel_decode.sv
module xbar_sel_decode #(
  parameter int NUM_IN = 68,
  parameter int ID_W   = 7
) (
  input  logic [ID_W-1:0]   code,
  output logic [NUM_IN-1:0] oneHot,
  output logic              off
);
  always_comb begin
    for (int k = 0; k < NUM_IN; k++) oneHot[k] = (int'(code) == k);
    off = (int'(code) >= NUM_IN);
  end
endmodule

// File: rtl/xbar_cfg_mem.sv
module xbar_cfg_mem #(
  parameter int NUM_OUT = 68,
  parameter int NUM_IN  = 68,
  parameter int ID_W    = 7,
  localparam int NUM_SLOT = NUM_OUT + 1,
  localparam int PAGE_W   = 2,
  localparam int PAGE_OUT = (NUM_OUT + 3) / 4,
  localparam int FIELD_W  = PAGE_W + PAGE_OUT
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       burstMode,
  input  logic                       muxAddrMode,
  input  logic                       loadIn,
  input  logic                       aleIn,
  input  logic                       commitIn,
  input  logic                       initIn,
  input  logic [ID_W-1:0]            inSel,
  input  logic [FIELD_W-1:0]         outField,
  output logic [NUM_SLOT*ID_W-1:0]   selCode,
  output logic [NUM_SLOT*NUM_IN-1:0] selOneHot,
  output logic [NUM_SLOT-1:0]        powerDown
);
  xbar_cfg_pkg::cfg_strobe_t stb;
  logic [ID_W-1:0] wrAddr;

  xbar_cfg_ctrl #(.ID_W(ID_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .burstMode(burstMode), .muxAddrMode(muxAddrMode),
    .loadIn(loadIn), .aleIn(aleIn), .commitIn(commitIn), .initIn(initIn),
    .inSel(inSel), .fieldAddr(outField[ID_W-1:0]), .stb(stb), .wrAddr(wrAddr)
  );

  xbar_cfg_datapath #(
    .NUM_OUT(NUM_OUT), .NUM_IN(NUM_IN), .ID_W(ID_W),
    .PAGE_OUT(PAGE_OUT), .PAGE_W(PAGE_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrAddr(wrAddr), .wrCode(inSel),
    .page(outField[PAGE_OUT +: PAGE_W]), .pageMap(outField[PAGE_OUT-1:0]),
    .mainCodes(selCode)
  );

  for (genvar s = 0; s < NUM_SLOT; s++) begin : g_dec
    xbar_sel_decode #(.NUM_IN(NUM_IN), .ID_W(ID_W)) i_dec (
      .code(selCode[s*ID_W +: ID_W]),
      .oneHot(selOneHot[s*NUM_IN +: NUM_IN]),
      .off(powerDown[s])
    );
  end
endmodule

// File: rtl/xbar_cfg_checker.sv
module xbar_cfg_checker #(
  parameter int NUM_OUT = 68,
  parameter int NUM_IN  = 68,
  parameter int ID_W    = 7
) (
  input logic                              clk,
  input logic                              rstN,
  input logic                              commitIn,
  input logic                              initIn,
  input logic [(NUM_OUT+1)*ID_W-1:0]       selCode,
  input logic [(NUM_OUT+1)*NUM_IN-1:0]     selOneHot,
  input logic [NUM_OUT:0]                  powerDown
);
  localparam int NUM_SLOT = NUM_OUT + 1;

  function automatic logic [NUM_SLOT*ID_W-1:0] straightMap();
    logic [NUM_SLOT*ID_W-1:0] v;
    for (int i = 0; i < NUM_SLOT; i++)
      v[i*ID_W +: ID_W] = (i < NUM_IN) ? ID_W'(i) : '1;
    return v;
  endfunction

  AST_HOLD_NO_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    (!commitIn && !initIn) |=> $stable(selCode)); // R3

  AST_INIT_STRAIGHT: assert property (@(posedge clk) disable iff (!rstN)
    initIn |=> (selCode == straightMap())); // R8

  for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot_chk
    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(selOneHot[s*NUM_IN +: NUM_IN])); // R10
    AST_OFF_NO_SEL: assert property (@(posedge clk) disable iff (!rstN)
      powerDown[s] |-> (selOneHot[s*NUM_IN +: NUM_IN] == '0)); // R9
    AST_ON_ONE_SEL: assert property (@(posedge clk) disable iff (!rstN)
      !powerDown[s] |-> ($countones(selOneHot[s*NUM_IN +: NUM_IN]) == 1)); // R10
  end
endmodule

bind xbar_cfg_mem xbar_cfg_checker #(
  .NUM_OUT(NUM_OUT), .NUM_IN(NUM_IN), .ID_W(ID_W)
) i_chk (
  .clk(clk), .rstN(rstN), .commitIn(commitIn), .initIn(initIn),
  .selCode(selCode), .selOneHot(selOneHot), .powerDown(powerDown)
);

// File: tb/test_xbar_cfg_mem.sv
module test_xbar_cfg_mem;
  localparam int NO = 10;
  localparam int NI = 10;
  localparam int IW = 4;
  localparam int NS = NO + 1;
  localparam int PO = (NO + 3) / 4;
  localparam int FW = 2 + PO;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic burstMode = 1'b0, muxAddrMode = 1'b0, loadIn = 1'b0, aleIn = 1'b0;
  logic commitIn = 1'b1, initIn = 1'b0;
  logic [IW-1:0] inSel = '0;
  logic [FW-1:0] outField = '0;
  logic [NS*IW-1:0] selCode;
  logic [NS*NI-1:0] selOneHot;
  logic [NS-1:0] powerDown;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  xbar_cfg_mem #(.NUM_OUT(NO), .NUM_IN(NI), .ID_W(IW)) i_xbar_cfg_mem (
    .clk(clk), .rstN(rstN), .burstMode(burstMode), .muxAddrMode(muxAddrMode),
    .loadIn(loadIn), .aleIn(aleIn), .commitIn(commitIn), .initIn(initIn),
    .inSel(inSel), .outField(outField), .selCode(selCode),
    .selOneHot(selOneHot), .powerDown(powerDown)
  );

  function automatic int codeOf(int i);
    return int'(selCode[i*IW +: IW]);
  endfunction

  function automatic int hotOf(int i);
    return int'(selOneHot[i*NI +: NI]);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chkCode(input string req, input int slot, input int exp);
    chk(codeOf(slot) == exp, req, codeOf(slot), exp);
  endtask

  task automatic doLoad(input logic [FW-1:0] fld, input logic [IW-1:0] code);
    @(negedge clk);
    outField = fld; inSel = code; loadIn = 1'b1;
    @(negedge clk);
    loadIn = 1'b0;
    @(negedge clk);
  endtask

  task automatic testReset();
    for (int i = 0; i < NI; i++) chkCode("R1 reset code", i, i);
    chkCode("R1 monitor disabled", NO, 15);
    chk(powerDown == 11'h400, "R1 powerDown", powerDown, 11'h400);
    chk(hotOf(3) == 8, "R10 onehot slot3", hotOf(3), 8);
  endtask

  task automatic testParallel();
    doLoad(5'd2, 4'd7);
    chkCode("R2 write slot2", 2, 7);
    chk(hotOf(2) == 128, "R10 onehot slot2", hotOf(2), 128);
    @(negedge clk); outField = 5'd2; inSel = 4'd1; loadIn = 1'b1;
    @(negedge clk); inSel = 4'd5;
    @(negedge clk); @(negedge clk);
    chkCode("R2 level ignored", 2, 1);
    loadIn = 1'b0;
    @(negedge clk);
  endtask

  task automatic testCommit();
    @(negedge clk); commitIn = 1'b0;
    doLoad(5'd4, 4'd1);
    @(negedge clk);
    chkCode("R3 held without commit", 4, 4);
    commitIn = 1'b1;
    @(negedge clk);
    chkCode("R3 applied on commit", 4, 1);
  endtask

  task automatic testMuxAddr();
    @(negedge clk); muxAddrMode = 1'b1; inSel = 4'd6; aleIn = 1'b1;
    @(negedge clk); aleIn = 1'b0;
    @(negedge clk);
    doLoad(5'd0, 4'd9);
    chkCode("R4 latched address", 6, 9);
    chkCode("R4 outField ignored", 0, 0);
    muxAddrMode = 1'b0;
  endtask

  task automatic testBurst();
    burstMode = 1'b1;
    doLoad({2'd1, 3'b101}, 4'd8);
    chkCode("R5 burst slot3", 3, 8);
    chkCode("R5 burst slot5", 5, 8);
    chkCode("R5 burst slot4 kept", 4, 1);
    chkCode("R5 other page kept", 0, 0);
    doLoad({2'd3, 3'b111}, 4'd2);
    chkCode("R6 page3 slot9", 9, 2);
    chkCode("R6 monitor untouched", NO, 15);
    chkCode("R6 page2 untouched", 8, 8);
    burstMode = 1'b0;
  endtask

  task automatic testRange();
    logic [NS*IW-1:0] snap;
    snap = selCode;
    doLoad(5'd12, 4'd0);
    chk(selCode == snap, "R7 out of range address", selCode, snap);
    doLoad(5'd10, 4'd5);
    chkCode("R7 monitor write", NO, 5);
    chk(powerDown[NO] == 1'b0, "R7 monitor enabled", powerDown[NO], 0);
  endtask

  task automatic testDisable();
    doLoad(5'd1, 4'd15);
    chk(powerDown[1] == 1'b1, "R9 disable pd", powerDown[1], 1);
    chk(hotOf(1) == 0, "R9 disable onehot", hotOf(1), 0);
    doLoad(5'd1, 4'd12);
    chk(powerDown[1] == 1'b1, "R9 code12 pd", powerDown[1], 1);
    doLoad(5'd1, 4'd10);
    chk(hotOf(1) == 0, "R9 code10 onehot", hotOf(1), 0);
    doLoad(5'd1, 4'd3);
    chk(powerDown[1] == 1'b0, "R9 re-enable pd", powerDown[1], 0);
    chk(hotOf(1) == 8, "R10 re-enable onehot", hotOf(1), 8);
  endtask

  task automatic testInit();
    @(negedge clk); commitIn = 1'b0; initIn = 1'b1;
    @(negedge clk); initIn = 1'b0;
    for (int i = 0; i < NI; i++) chkCode("R8 init code", i, i);
    chkCode("R8 init monitor", NO, 15);
    commitIn = 1'b1;
    @(negedge clk);
    chkCode("R8 shadow reloaded", 2, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testParallel();
    testCommit();
    testMuxAddr();
    testBurst();
    testRange();
    testDisable();
    testInit();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule